// File: doc/BRIEF.md
# Holdover Frequency Capture Unit

This block keeps the frequency word that a digital PLL falls back on when it loses every usable input and goes into holdover. While the loop is locked, it watches the word from the integral path of the loop filter. It uses that word only, so recent phase hits that reach the proportional path never reach the stored value. From those samples it keeps two things. The first is a short history of periodic snapshots, which gives a copy that is always one to two snapshot periods old. The second is a running block average over a power-of-two window of samples.

A pulse on the entry input marks the moment the loop enters holdover. On that pulse the block chooses one of three values and freezes it on its output: a fixed programmed offset for free-run operation, the latest complete average, or the delayed snapshot. The delayed snapshot is also used when averaging is requested but no full window has been collected yet. With the default parameters and a 1 ms sample strobe, the snapshots are 50 ms apart, so the delayed copy is 50 to 100 ms old. The averaging window is 1024 samples, which is about one second.

Top module: `holdover_capture`

## Requirements
- R1: During and directly after reset, `hold_freq` is 0 and `avg_ready` is 0.
- R2: A sample is taken when `freq_valid` and `dpll_locked` are both 1. Every SNAP_DIV-th taken sample is written into a two-entry history, and the earlier entry moves to the older slot. The delayed value is the older slot, which reads 0 until two snapshots exist.
- R3: With `freerun`=0 and `avg_mode`=0, a `hold_entry` pulse loads the delayed value into `hold_freq`.
- R4: The taken samples are summed in blocks of 2^AVG_LOG2, as signed two's-complement values. At the end of each block the average becomes the sum divided by 2^AVG_LOG2, rounded toward minus infinity. `avg_ready` rises with the first complete block and stays 1 until reset.
- R5: With `freerun`=0, `avg_mode`=1 and `avg_ready`=1, a `hold_entry` pulse loads the latest complete average.
- R6: With `freerun`=0, `avg_mode`=1 and `avg_ready`=0, a `hold_entry` pulse loads the delayed value.
- R7: With `freerun`=1, a `hold_entry` pulse loads `freerun_offset`, whatever the value of `avg_mode`.
- R8: Samples presented while `dpll_locked`=0 count toward neither the snapshot history nor the average, and the partial counts of both pause until lock returns.
- R9: `hold_freq` changes only on the clock edge that samples `hold_entry`=1. The selection on that edge uses the history and average as they stood before that edge. `hold_freq` then holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_in | input | FREQ_W | Signed frequency word from the integral path |
| freq_valid | input | 1 | One-cycle strobe marking a new `freq_in` sample |
| dpll_locked | input | 1 | High while the loop is phase locked |
| hold_entry | input | 1 | One-cycle pulse on entry to holdover |
| avg_mode | input | 1 | 1 selects the averaged value, 0 the delayed value |
| freerun | input | 1 | 1 selects the programmed offset |
| freerun_offset | input | FREQ_W | Signed offset word used in free-run operation |
| hold_freq | output | FREQ_W | Frozen signed holdover frequency word |
| avg_ready | output | 1 | A complete average is available |

## Verification
The assertions assume the following about the inputs:
- `hold_entry` is a single-cycle pulse.
- `freerun_offset` and the two mode bits are steady on the cycle of the pulse.
- A window completes only on an edge with a taken sample.

The bench meets these by driving every input on the falling edge. It never raises `hold_entry` on the same cycle as a valid sample, so no selection overlaps a history or average update. It also mixes unlocked samples and idle cycles into the sample stream so that the paused counts are exercised.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    typedef enum logic [1:0] {
        SRC_DELAYED = 2'd0,
        SRC_AVERAGE = 2'd1,
        SRC_OFFSET  = 2'd2
    } hold_src_e;

    // Source priority: free-run offset, then a ready average, else delayed copy.
    function automatic hold_src_e pick_source(input logic freerun,
                                              input logic avg_mode,
                                              input logic avg_ready);
        if (freerun)
            return SRC_OFFSET;
        else if (avg_mode && avg_ready)
            return SRC_AVERAGE;
        else
            return SRC_DELAYED;
    endfunction

endpackage

// File: rtl/hfc_snapshot.sv
module hfc_snapshot #(
    parameter int W   = 24,
    parameter int DIV = 50
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] delayed
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic signed [W-1:0] newer;
        logic signed [W-1:0] older;
    } history_t;

    history_t         hist;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            cnt  <= '0;
        end else if (take) begin
            if (cnt == LAST) begin
                cnt        <= '0;
                hist.older <= hist.newer;
                hist.newer <= din;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign delayed = hist.older;
endmodule

// File: rtl/hfc_averager.sv
module hfc_averager #(
    parameter int W    = 24,
    parameter int LOG2 = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] avg,
    output logic                ready
);
    localparam int ACC_W = W + LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum;
    logic        [LOG2-1:0]  cnt;

    assign sum = acc + {{LOG2{din[W-1]}}, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            cnt   <= '0;
            avg   <= '0;
            ready <= 1'b0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
            if (&cnt) begin
                // Dropping the low LOG2 bits floors the signed quotient.
                avg   <= sum[ACC_W-1:LOG2];
                ready <= 1'b1;
                acc   <= '0;
            end else begin
                acc <= sum;
            end
        end
    end
endmodule

// File: rtl/holdover_capture.sv
module holdover_capture #(
    parameter int FREQ_W   = 24,
    parameter int SNAP_DIV = 50,
    parameter int AVG_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic              freq_valid,
    input  logic              dpll_locked,
    input  logic              hold_entry,
    input  logic              avg_mode,
    input  logic              freerun,
    input  logic [FREQ_W-1:0] freerun_offset,
    output logic [FREQ_W-1:0] hold_freq,
    output logic              avg_ready
);
    import hfc_pkg::*;

    logic                     sample_take;
    logic signed [FREQ_W-1:0] delayed_word;
    logic signed [FREQ_W-1:0] avg_word;
    hold_src_e                src;

    assign sample_take = freq_valid && dpll_locked;

    hfc_snapshot #(.W(FREQ_W), .DIV(SNAP_DIV)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .take    (sample_take),
        .din     (freq_in),
        .delayed (delayed_word)
    );

    hfc_averager #(.W(FREQ_W), .LOG2(AVG_LOG2)) u_avg (
        .clk   (clk),
        .rst   (rst),
        .take  (sample_take),
        .din   (freq_in),
        .avg   (avg_word),
        .ready (avg_ready)
    );

    assign src = pick_source(freerun, avg_mode, avg_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_freq <= '0;
        end else if (hold_entry) begin
            case (src)
                SRC_OFFSET:  hold_freq <= freerun_offset;
                SRC_AVERAGE: hold_freq <= avg_word;
                default:     hold_freq <= delayed_word;
            endcase
        end
    end
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         hold_entry,
    input logic         freerun,
    input logic         avg_mode,
    input logic [W-1:0] freerun_offset,
    input logic [W-1:0] hold_freq,
    input logic         avg_ready,
    input logic [W-1:0] avg_word,
    input logic [W-1:0] delayed_word,
    input logic         sample_take
);
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !hold_entry |=> $stable(hold_freq));

    p_offset_load_r7: assert property (@(posedge clk) disable iff (rst)
        (hold_entry && freerun) |=> hold_freq == $past(freerun_offset));

    p_avg_load_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_entry && !freerun && avg_mode && avg_ready)
        |=> hold_freq == $past(avg_word));

    p_fallback_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_entry && !freerun && avg_mode && !avg_ready)
        |=> hold_freq == $past(delayed_word));

    p_inst_load_r3: assert property (@(posedge clk) disable iff (rst)
        (hold_entry && !freerun && !avg_mode)
        |=> hold_freq == $past(delayed_word));

    p_ready_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        avg_ready |=> avg_ready);

    p_ready_needs_take_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(avg_ready) |-> $past(sample_take));
endmodule

bind holdover_capture hfc_checker #(.W(FREQ_W)) u_hfc_checker (
    .clk            (clk),
    .rst            (rst),
    .hold_entry     (hold_entry),
    .freerun        (freerun),
    .avg_mode       (avg_mode),
    .freerun_offset (freerun_offset),
    .hold_freq      (hold_freq),
    .avg_ready      (avg_ready),
    .avg_word       (avg_word),
    .delayed_word   (delayed_word),
    .sample_take    (sample_take)
);

// File: tb/test_holdover_capture.sv
module test_holdover_capture;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 16;
    localparam int SNAP = 4;
    localparam int LOG2 = 4;
    localparam int WIN  = 1 << LOG2;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] freq_in;
    logic         freq_valid;
    logic         dpll_locked;
    logic         hold_entry;
    logic         avg_mode;
    logic         freerun;
    logic [W-1:0] freerun_offset;
    logic [W-1:0] hold_freq;
    logic         avg_ready;

    holdover_capture #(.FREQ_W(W), .SNAP_DIV(SNAP), .AVG_LOG2(LOG2)) i_holdover_capture (
        .clk(clk), .rst(rst), .freq_in(freq_in), .freq_valid(freq_valid),
        .dpll_locked(dpll_locked), .hold_entry(hold_entry), .avg_mode(avg_mode),
        .freerun(freerun), .freerun_offset(freerun_offset),
        .hold_freq(hold_freq), .avg_ready(avg_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int errors  = 0;

    // Reference model state.
    int     m_new = 0, m_old = 0, m_scnt = 0, m_acnt = 0, m_avg = 0;
    longint m_acc = 0;
    bit     m_ready = 0;
    int     last_exp = 0;

    int   exp_q[$];
    string tag_q[$];
    logic entry_seen = 1'b0;

    function automatic int sval(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compares each frozen word one edge after its entry pulse.
    always @(posedge clk) entry_seen <= hold_entry;
    always @(negedge clk) begin
        if (entry_seen && exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, sval(hold_freq), e);
        end
    end

    task automatic feed(input int v, input bit lock);
        @(negedge clk);
        freq_in     = W'(v);
        freq_valid  = 1'b1;
        dpll_locked = lock;
        if (lock) begin
            m_scnt++;
            if (m_scnt == SNAP) begin
                m_old  = m_new;
                m_new  = v;
                m_scnt = 0;
            end
            m_acc += v;
            m_acnt++;
            if (m_acnt == WIN) begin
                if (m_acc >= 0) m_avg = int'(m_acc / WIN);
                else            m_avg = -int'((-m_acc + WIN - 1) / WIN);
                m_ready = 1;
                m_acc   = 0;
                m_acnt  = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            freq_valid = 1'b0;
        end
    endtask

    // Driver: pushes the expected frozen word, then pulses hold_entry.
    task automatic entry(input bit am, input bit fr, input int off, input string tag);
        int e;
        @(negedge clk);
        freq_valid     = 1'b0;
        avg_mode       = am;
        freerun        = fr;
        freerun_offset = W'(off);
        if (fr)                e = off;
        else if (am && m_ready) e = m_avg;
        else                   e = m_old;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp   = e;
        hold_entry = 1'b1;
        @(negedge clk);
        hold_entry = 1'b0;
        idle(1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; freq_in = '0; freq_valid = 1'b0; dpll_locked = 1'b0;
        hold_entry = 1'b0; avg_mode = 1'b0; freerun = 1'b0; freerun_offset = '0;
        repeat (3) @(negedge clk);
        check("R1 hold_freq in reset", sval(hold_freq), 0);
        check("R1 ready in reset", int'(avg_ready), 0);
        rst = 1'b0;
        idle(1);
        check("R1 hold_freq after reset", sval(hold_freq), 0);

        // R2: one snapshot only, so the older slot still reads zero.
        for (int k = 1; k <= 5; k++) feed(100 + k, 1'b1);
        entry(1'b0, 1'b0, 0, "R2 older slot empty");

        // R8: unlocked samples with large values must not count.
        for (int k = 0; k < 6; k++) feed(-3000, 1'b0);
        for (int k = 6; k <= 12; k++) begin
            feed(100 + k, 1'b1);
            if (k % 3 == 0) idle(1);
        end
        entry(1'b1, 1'b0, 0, "R6 fallback before ready");
        check("R4 not ready at 12 samples", int'(avg_ready), 0);
        entry(1'b0, 1'b0, 0, "R3 delayed snapshot");

        for (int k = 13; k <= 15; k++) feed(100 + k, 1'b1);
        idle(1);
        check("R4 ready still low at 15", int'(avg_ready), 0);
        feed(116, 1'b1);
        idle(1);
        check("R4 ready after full window", int'(avg_ready), 1);
        entry(1'b1, 1'b0, 0, "R5 average load");

        // R9: output frozen while samples keep arriving.
        for (int k = 0; k < 5; k++) feed(7 * k - 20, 1'b1);
        idle(1);
        check("R9 hold_freq frozen", sval(hold_freq), last_exp);

        entry(1'b1, 1'b1, -1234, "R7 offset overrides average");
        entry(1'b0, 1'b1, 555, "R7 offset in instantaneous");

        // Negative window to check floor rounding (R4) and sticky ready.
        for (int k = 0; k < 11; k++) feed(-(k * 13) - 1, 1'b1);
        check("R4 ready stays set", int'(avg_ready), 1);
        entry(1'b1, 1'b0, 0, "R5 negative floor average");
        entry(1'b0, 1'b0, 0, "R3 delayed after more snapshots");

        // R8: unlocked stretch leaves the average and the history unchanged.
        for (int k = 0; k < 20; k++) feed(32000, 1'b0);
        entry(1'b1, 1'b0, 0, "R8 average unchanged by unlocked samples");
        entry(1'b0, 1'b0, 0, "R8 history unchanged by unlocked samples");

        idle(3);
        check("R9 hold_freq held at end", sval(hold_freq), last_exp);
        check("scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule